// File: doc/BRIEF.md
# Count-Based Event Pacing Divider

This block thins a stream of single-cycle event strobes, such as per-packet completion signals, into a slower stream of single-cycle output pulses. One pulse is produced for every N accepted events, where N comes from a programmable count setting. A restart strobe puts the count back to its starting point. The block is meant to pace interrupts in a packet engine, so that software is not interrupted for every completion.

A separate time setting selects timer-based pacing. While that setting is non-zero, another pacer outside this block is responsible, and this divider stays idle. When both settings are zero, there is no pacing, and every event is passed through as a pulse.

Internally, a three-state control machine (waiting, counting, output) decides on each event whether to advance, reload or fire. It drives a small datapath that holds an event counter and the registered output pulse.

Top module: `evt_pace_div`

## Requirements
- R1: After synchronous reset, `pulseOut` is 0 and the internal count starts at 1, so with a count setting of N the first pulse follows the N-th event.
- R2: With `timeCfg` = 0 and `cntCfg` = N (N ≥ 1), one pulse is produced for each N accepted events, and the count reloads to 1 on every pulse. This also holds at N = 255.
- R3: With `timeCfg` = 0 and `cntCfg` of 0 or 1, every event produces a pulse.
- R4: A pulse is 1 in the cycle right after the clock edge that samples the causing event. It lasts exactly one cycle, and each event yields at most one pulse.
- R5: While `timeCfg` is non-zero, no pulses are produced and events do not advance the count. The progress made before disabling is kept after `timeCfg` returns to 0.
- R6: `cntRestart` together with an event whose count is below the setting reloads the count to 1 without a pulse. The next pulse then follows the N-th later event.
- R7: `cntRestart` without an event reloads the count to 1, so the next pulse follows the N-th later event.
- R8: An event whose count is at or above the setting fires a pulse even when `cntRestart` is asserted in the same cycle.
- R9: If `cntCfg` is lowered to or below the current count, the next event fires a pulse. The counter never wraps.
- R10: A change to `cntCfg` during counting takes effect at the next event, which is compared against the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evtIn | input | 1 | Single-cycle event strobe |
| cntRestart | input | 1 | Reloads the event count to 1 |
| cntCfg | input | 8 | Events per output pulse; 0 and 1 both mean every event |
| timeCfg | input | 8 | Non-zero hands pacing to a timer pacer and idles this block |
| pulseOut | output | 1 | Divided output pulse, one cycle wide |

## Verification
Every pulse is due exactly one clock edge after the event that causes it. For that reason, the bench drives each stimulus on a falling edge and reads `pulseOut` at the next falling edge, which puts one rising edge between stimulus and sample. Counter reloads and suppressed events have no direct output, so they are judged by the event on which the next pulse lands. The vector table therefore continues each such case until that pulse is due. The long run with a setting of 255 is checked for silence over its first 254 events and for a pulse on the 255th.

// File: rtl/evt_pace_pkg.sv
package evt_pace_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_OUTPUT = 2'd2
  } paceState_t;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic reloadOne;
    logic incr;
    logic fire;
  } dpStrobe_t;

endpackage

// File: rtl/evt_pace_ctrl.sv
module evt_pace_ctrl
  import evt_pace_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evtIn,
  input  logic              cntRestart,
  input  logic [TIME_W-1:0] timeCfg,
  input  logic              atLimit,
  output dpStrobe_t         strobe,
  output paceState_t        state
);

  paceState_t nextState;
  logic       divEnabled;

  assign divEnabled = (timeCfg == '0);

  always_comb begin
    strobe    = '0;
    nextState = ST_WAIT;
    if (evtIn && divEnabled) begin
      if (atLimit) begin
        strobe.fire = 1'b1;
        nextState   = ST_OUTPUT;
      end else if (cntRestart) begin
        strobe.reloadOne = 1'b1;
        nextState        = ST_COUNT;
      end else begin
        strobe.incr = 1'b1;
        nextState   = ST_COUNT;
      end
    end else if (cntRestart) begin
      strobe.reloadOne = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else     state <= nextState;
  end

  // R4: output state only follows an accepted event
  assert_output_needs_event_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OUTPUT) |-> ($past(evtIn) && ($past(timeCfg) == '0)));

  // R4: strobes never overlap
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  // R5: disabled divider never reaches output
  assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (timeCfg != '0) |=> (state != ST_OUTPUT));

endmodule

// File: rtl/evt_pace_dpath.sv
module evt_pace_dpath
  import evt_pace_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] cntCfg,
  output logic             atLimit,
  output logic             pulseQ
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] evtCount;
  logic [CNT_W-1:0] countPlus;

  // Comparison with >= covers a setting lowered below the current count.
  assign atLimit   = (evtCount >= cntCfg);
  assign countPlus = (evtCount == CNT_MAX) ? CNT_MAX : evtCount + CNT_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      evtCount <= CNT_ONE;
      pulseQ   <= 1'b0;
    end else begin
      pulseQ <= strobe.fire;
      if (strobe.fire || strobe.reloadOne) evtCount <= CNT_ONE;
      else if (strobe.incr)                evtCount <= countPlus;
    end
  end

  // R1: counter never sits at zero
  assert_cnt_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    evtCount != '0);

  // R2: firing reloads the count and raises the pulse
  assert_fire_reload_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.fire |=> (evtCount == CNT_ONE) && pulseQ);

  // R6: a restart reload leaves the pulse low
  assert_restart_reload_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.reloadOne |=> (evtCount == CNT_ONE) && !pulseQ);

  // R9: counting never wraps to a smaller value
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.incr |=> (evtCount > $past(evtCount)) || (evtCount == CNT_MAX));

endmodule

// File: rtl/evt_pace_div.sv
module evt_pace_div
  import evt_pace_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evtIn,
  input  logic              cntRestart,
  input  logic [CNT_W-1:0]  cntCfg,
  input  logic [TIME_W-1:0] timeCfg,
  output logic              pulseOut
);

  dpStrobe_t  strobe;
  paceState_t state;
  logic       atLimit;

  evt_pace_ctrl #(.TIME_W(TIME_W)) ctrl_i (
    .clk(clk), .rst(rst), .evtIn(evtIn), .cntRestart(cntRestart),
    .timeCfg(timeCfg), .atLimit(atLimit), .strobe(strobe), .state(state)
  );

  evt_pace_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .cntCfg(cntCfg),
    .atLimit(atLimit), .pulseQ(pulseOut)
  );

  // R4: the pulse and the output state agree
  assert_pulse_state_R4: assert property (@(posedge clk) disable iff (rst)
    pulseOut == (state == ST_OUTPUT));

endmodule

// File: tb/evt_pace_div_tb.sv
module evt_pace_div_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       evtIn;
  logic       cntRestart;
  logic [7:0] cntCfg;
  logic [7:0] timeCfg;
  logic       pulseOut;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  evt_pace_div dut_i (
    .clk(clk), .rst(rst), .evtIn(evtIn), .cntRestart(cntRestart),
    .cntCfg(cntCfg), .timeCfg(timeCfg), .pulseOut(pulseOut)
  );

  // {evt, restart, cntCfg, timeCfg, expected pulse one edge later}
  localparam int NVEC = 41;
  localparam logic [18:0] VECS [NVEC] = '{
    {1'b1,1'b0,8'd3,8'd0,1'b0},  // R2
    {1'b1,1'b0,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b1},
    {1'b0,1'b0,8'd3,8'd0,1'b0},  // R4 single-cycle width
    {1'b1,1'b0,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b1},
    {1'b1,1'b0,8'd0,8'd0,1'b1},  // R3
    {1'b1,1'b0,8'd0,8'd0,1'b1},
    {1'b1,1'b0,8'd1,8'd0,1'b1},
    {1'b1,1'b0,8'd3,8'd0,1'b0},  // R7
    {1'b0,1'b1,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b1},
    {1'b1,1'b0,8'd3,8'd0,1'b0},  // R6
    {1'b1,1'b1,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b0},
    {1'b1,1'b0,8'd3,8'd0,1'b1},
    {1'b1,1'b0,8'd2,8'd5,1'b0},  // R5
    {1'b1,1'b0,8'd2,8'd5,1'b0},
    {1'b1,1'b0,8'd2,8'd5,1'b0},
    {1'b1,1'b0,8'd0,8'd5,1'b0},
    {1'b1,1'b0,8'd2,8'd0,1'b0},
    {1'b1,1'b0,8'd2,8'd0,1'b1},
    {1'b1,1'b0,8'd4,8'd0,1'b0},  // R9
    {1'b1,1'b0,8'd4,8'd0,1'b0},
    {1'b1,1'b0,8'd2,8'd0,1'b1},
    {1'b1,1'b0,8'd4,8'd0,1'b0},  // R8
    {1'b1,1'b0,8'd4,8'd0,1'b0},
    {1'b1,1'b1,8'd4,8'd0,1'b0},
    {1'b1,1'b0,8'd2,8'd0,1'b0},
    {1'b1,1'b1,8'd2,8'd0,1'b1},
    {1'b1,1'b0,8'd2,8'd0,1'b0},
    {1'b1,1'b0,8'd2,8'd0,1'b1},
    {1'b1,1'b0,8'd2,8'd0,1'b0},  // R10
    {1'b1,1'b0,8'd5,8'd0,1'b0},
    {1'b1,1'b0,8'd5,8'd0,1'b0},
    {1'b1,1'b0,8'd5,8'd0,1'b0},
    {1'b1,1'b0,8'd5,8'd0,1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pulseOut=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic e, input logic r, input logic [7:0] c, input logic [7:0] t);
    @(negedge clk);
    evtIn = e; cntRestart = r; cntCfg = c; timeCfg = t;
  endtask

  function automatic string vecReq(input int i);
    if (i < 7)  return "R2";
    if (i < 10) return "R3";
    if (i < 15) return "R7";
    if (i < 20) return "R6";
    if (i < 26) return "R5";
    if (i < 29) return "R9";
    if (i < 36) return "R8";
    return "R10";
  endfunction

  initial begin
    rst = 1'b1; evtIn = 1'b0; cntRestart = 1'b0; cntCfg = 8'd0; timeCfg = 8'd0;
    repeat (3) @(negedge clk);
    check("R1", pulseOut, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i][18], VECS[i][17], VECS[i][16:9], VECS[i][8:1]);
      @(negedge clk);
      check(vecReq(i), pulseOut, VECS[i][0]);
      evtIn = 1'b0; cntRestart = 1'b0;
    end

    // R1: reset mid-count restores the start count
    step(1'b1, 1'b0, 8'd3, 8'd0);
    step(1'b1, 1'b0, 8'd3, 8'd0);
    step(1'b0, 1'b0, 8'd3, 8'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", pulseOut, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      step(1'b1, 1'b0, 8'd3, 8'd0);
      @(negedge clk);
      check("R1", pulseOut, (k == 3));
      evtIn = 1'b0;
    end

    // R2: largest setting, 255 events per pulse
    begin
      bit early = 1'b0;
      for (int k = 1; k < 255; k++) begin
        step(1'b1, 1'b0, 8'd255, 8'd0);
        @(negedge clk);
        if (pulseOut) early = 1'b1;
        evtIn = 1'b0;
      end
      check("R2", early, 1'b0);
      step(1'b1, 1'b0, 8'd255, 8'd0);
      @(negedge clk);
      check("R2", pulseOut, 1'b1);
      evtIn = 1'b0;
      @(negedge clk);
      check("R4", pulseOut, 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule